// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Sticky Saturation Flag

This block adds or subtracts two operands of a configurable width (32 bits by default). A 3-bit opcode selects the operation. One mode is a plain wrapping add that only flags signed overflow. Two modes are signed saturating add and subtract, which clamp to the most positive or most negative value. The last two are unsigned saturating add and subtract, which clamp to all ones or to zero. The result is combinational from the operands and the opcode.

A single sticky flag records that saturation, or signed overflow in the flagging add mode, has happened since it was last cleared. The flag is a two-state machine with states `Q_CLEAR` and `Q_SET`, and it changes only on a clock edge where the valid strobe is high. The transition into `Q_SET` is taken when the current operation raises a saturation event. The transition into `Q_CLEAR` is taken when the clear input is high and there is no event. In every other case the state holds.

Top module: `sat_addsub_unit`

## Requirements
- R1: Opcode 0 (wrap-and-flag add) outputs (a + b) modulo 2^WIDTH without clamping. Its event is signed overflow: both operands have the same sign bit and the sum's sign bit differs from that of a.
- R2: Opcode 1 (signed saturating add) outputs the wrapped sum when there is no signed overflow. On overflow it outputs the most positive value (0x7FFFFFFF at 32 bits) when a is non-negative, and the most negative value (0x80000000) when a is negative.
- R3: Opcode 2 (signed saturating subtract) outputs a - b. It overflows when the operand sign bits differ and the difference's sign bit differs from that of a. On overflow it clamps exactly as in R2, based on the sign of a.
- R4: Opcode 3 (unsigned saturating add) outputs the all-ones value when the sum carries out of the top bit. Otherwise it outputs the sum.
- R5: Opcode 4 (unsigned saturating subtract) outputs 0 when b is greater than a (a borrow). Otherwise it outputs a - b.
- R6: At a rising clock edge with valid high and a saturation event (the overflow of R1 to R3, the carry of R4 or the borrow of R5), the flag q_o becomes 1.
- R7: The flag holds its value at an edge where valid is high with no event and no clear. It also holds at any edge where valid is low, whatever the clear input and the operands are.
- R8: At an edge with valid and clear both high, q_o becomes 0 when there is no event. When there is an event, setting wins and q_o becomes 1.
- R9: An active-low reset clears q_o to 0.
- R10: The unused opcodes 5, 6 and 7 behave exactly as opcode 0, for both the result and the event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Strobe that allows the flag to update at this edge |
| clr_i | input | 1 | Request to clear the sticky flag (acts only with valid_i) |
| op_i | input | 3 | Operation select, encoded as in R1 to R5 and R10 |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| res_o | output | WIDTH | Combinational result |
| q_o | output | 1 | Sticky saturation flag |

## Verification
On every cycle, the assertions check the flag-machine rules:
- an event under valid sets the flag;
- valid low freezes the flag;
- a clear without an event drops the flag.

They also check the result against the operands in a coarse way. An unsigned add never falls below a, and an unsigned subtract never rises above a. A signed add that overflows lands on one of the two clamp values.

The exact value of every result, including which clamp value is chosen, comes only from the bench. The bench sweeps all opcodes over all 8-bit operand pairs, and runs directed 32-bit boundary cases against its own arithmetic model. Only the bench scenarios can show the following:
- set winning over clear;
- the flag surviving a long run of events while valid is low;
- reset in the middle of a run.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;

    localparam int OP_W = 3;

    // Operation codes; codes 5..7 fall back to the wrap-and-flag add.
    localparam logic [OP_W-1:0] OP_WRAPF = 3'd0;
    localparam logic [OP_W-1:0] OP_SADD  = 3'd1;
    localparam logic [OP_W-1:0] OP_SSUB  = 3'd2;
    localparam logic [OP_W-1:0] OP_UADD  = 3'd3;
    localparam logic [OP_W-1:0] OP_USUB  = 3'd4;

    // States of the sticky-flag machine.
    typedef enum logic {
        Q_CLEAR = 1'b0,
        Q_SET   = 1'b1
    } qstate_e;

endpackage

// File: rtl/sat_arith_core.sv
`timescale 1ns/1ps
module sat_arith_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] diff,
    output logic             carry,
    output logic             borrow,
    output logic             sovf_add,
    output logic             sovf_sub
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] sum_x;
    logic [WIDTH:0] diff_x;

    always_comb begin
        sum_x  = {1'b0, a} + {1'b0, b};
        diff_x = {1'b0, a} - {1'b0, b};
        sum    = sum_x[MSB:0];
        diff   = diff_x[MSB:0];
        carry  = sum_x[WIDTH];
        borrow = diff_x[WIDTH];
        // Like signs in, different sign out (relative to a).
        sovf_add = (a[MSB] == b[MSB]) && (sum_x[MSB] != a[MSB]);
        // Unlike signs in, result sign departs from a.
        sovf_sub = (a[MSB] != b[MSB]) && (diff_x[MSB] != a[MSB]);
    end

endmodule

// File: rtl/sat_select.sv
`timescale 1ns/1ps
module sat_select
    import sat_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [OP_W-1:0]  op,
    input  logic             a_neg,
    input  logic [WIDTH-1:0] sum,
    input  logic [WIDTH-1:0] diff,
    input  logic             carry,
    input  logic             borrow,
    input  logic             sovf_add,
    input  logic             sovf_sub,
    output logic [WIDTH-1:0] res,
    output logic             evt
);

    localparam logic [WIDTH-1:0] SMAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] SMIN = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] UMAX = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] sclamp;

    always_comb begin
        sclamp = a_neg ? SMIN : SMAX;
        case (op)
            OP_SADD: begin
                evt = sovf_add;
                res = sovf_add ? sclamp : sum;
            end
            OP_SSUB: begin
                evt = sovf_sub;
                res = sovf_sub ? sclamp : diff;
            end
            OP_UADD: begin
                evt = carry;
                res = carry ? UMAX : sum;
            end
            OP_USUB: begin
                evt = borrow;
                res = borrow ? ZERO : diff;
            end
            default: begin
                // Wrap-and-flag add (code 0 and unused codes).
                evt = sovf_add;
                res = sum;
            end
        endcase
    end

endmodule

// File: rtl/sat_q_fsm.sv
`timescale 1ns/1ps
module sat_q_fsm
    import sat_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic valid_i,
    input  logic clr_i,
    input  logic evt_i,
    output logic q_o
);

    qstate_e state_q;
    qstate_e state_d;

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= Q_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and output.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_CLEAR: begin
                if (valid_i && evt_i) state_d = Q_SET;
            end
            Q_SET: begin
                if (valid_i && clr_i && !evt_i) state_d = Q_CLEAR;
            end
            default: state_d = Q_CLEAR;
        endcase
        q_o = (state_q == Q_SET);
    end

    // R6: an event under valid always sets the flag.
    p_evt_sets_q_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && evt_i) |=> q_o);

    // R7: without valid the flag cannot move.
    p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(q_o));

    // R8: clear without an event drops the flag.
    p_clear_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && clr_i && !evt_i) |=> !q_o);

endmodule

// File: rtl/sat_addsub_unit.sv
`timescale 1ns/1ps
module sat_addsub_unit
    import sat_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             valid_i,
    input  logic             clr_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o,
    output logic             q_o
);

    localparam logic [WIDTH-1:0] SMAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] SMIN = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] diff;
    logic             carry;
    logic             borrow;
    logic             sovf_add;
    logic             sovf_sub;
    logic             evt;

    sat_arith_core #(.WIDTH(WIDTH)) core_i (
        .a        (a_i),
        .b        (b_i),
        .sum      (sum),
        .diff     (diff),
        .carry    (carry),
        .borrow   (borrow),
        .sovf_add (sovf_add),
        .sovf_sub (sovf_sub)
    );

    sat_select #(.WIDTH(WIDTH)) sel_i (
        .op       (op_i),
        .a_neg    (a_i[WIDTH-1]),
        .sum      (sum),
        .diff     (diff),
        .carry    (carry),
        .borrow   (borrow),
        .sovf_add (sovf_add),
        .sovf_sub (sovf_sub),
        .res      (res_o),
        .evt      (evt)
    );

    sat_q_fsm flag_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (valid_i),
        .clr_i   (clr_i),
        .evt_i   (evt),
        .q_o     (q_o)
    );

    // R4: unsigned saturating add never yields less than a.
    p_uadd_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_UADD) |-> (res_o >= a_i));

    // R5: unsigned saturating subtract never yields more than a.
    p_usub_ceiling_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_USUB) |-> (res_o <= a_i));

    // R2: an overflowing signed add lands on a clamp value.
    p_sadd_clamp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_SADD && sovf_add) |-> (res_o == SMAX || res_o == SMIN));

endmodule

// File: tb/sat_addsub_unit_tb_top.sv
`timescale 1ns/1ps
module sat_addsub_unit_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  W_MAIN     = 32;
    localparam int  W_SWEEP    = 8;
    localparam longint WATCHDOG_NS = 64'd1_900_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid = 1'b0;
    logic clr = 1'b0;
    logic [2:0] op = 3'd0;
    logic [W_MAIN-1:0] a = '0;
    logic [W_MAIN-1:0] b = '0;
    logic [W_MAIN-1:0] res;
    logic q;

    logic [2:0] s_op = 3'd0;
    logic [W_SWEEP-1:0] s_a = '0;
    logic [W_SWEEP-1:0] s_b = '0;
    logic [W_SWEEP-1:0] s_res;
    logic s_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit q_exp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_addsub_unit #(.WIDTH(W_MAIN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .clr_i(clr),
        .op_i(op), .a_i(a), .b_i(b), .res_o(res), .q_o(q)
    );

    sat_addsub_unit #(.WIDTH(W_SWEEP)) sweep_i (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(1'b0), .clr_i(1'b1),
        .op_i(s_op), .a_i(s_a), .b_i(s_b), .res_o(s_res), .q_o(s_q)
    );

    // Arithmetic model of R1..R5 and R10, written over wide integers.
    function automatic void model(input int w, input int code, input longint ua,
                                  input longint ub, output longint r, output bit ev);
        longint mask, half, mx, mn, sa, sb, t;
        mask = (longint'(1) <<< w) - 1;
        half = longint'(1) <<< (w - 1);
        mx = half - 1;
        mn = -half;
        sa = (ua >= half) ? ua - (mask + 1) : ua;
        sb = (ub >= half) ? ub - (mask + 1) : ub;
        case (code)
            1, 2: begin
                t  = (code == 1) ? sa + sb : sa - sb;
                ev = (t > mx) || (t < mn);
                if (t > mx) t = mx;
                if (t < mn) t = mn;
                r = t & mask;
            end
            3: begin
                t  = ua + ub;
                ev = t > mask;
                r  = ev ? mask : t;
            end
            4: begin
                t  = ua - ub;
                ev = t < 0;
                r  = ev ? 0 : t;
            end
            default: begin
                t  = sa + sb;
                ev = (t > mx) || (t < mn);
                r  = (ua + ub) & mask;
            end
        endcase
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One 32-bit operation: result checked before the edge, flag after it.
    task automatic step(input string req, input bit v, input bit c, input int code,
                        input logic [W_MAIN-1:0] x, input logic [W_MAIN-1:0] y);
        longint r;
        bit ev;
        @(negedge clk);
        valid = v; clr = c; op = 3'(code); a = x; b = y;
        #1;
        model(W_MAIN, code, longint'(x), longint'(y), r, ev);
        chk(req, longint'(res), r);
        if (v) begin
            if (ev) q_exp = 1'b1;
            else if (c) q_exp = 1'b0;
        end
        @(negedge clk);
        chk(req, longint'(q), longint'(q_exp));
        valid = 1'b0; clr = 1'b0;
    endtask

    initial begin : watchdog
        #(WATCHDOG_NS);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (2) @(negedge clk);
        chk("R9 reset", longint'(q), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 after release", longint'(q), 0);

        // Exhaustive 8-bit result sweep over every opcode (R1-R5, R10).
        for (int c = 0; c < 8; c++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    longint r;
                    bit ev;
                    s_op = 3'(c); s_a = 8'(x); s_b = 8'(y);
                    #1;
                    model(W_SWEEP, c, longint'(x), longint'(y), r, ev);
                    case (c)
                        0: chk("R1 sweep", longint'(s_res), r);
                        1: chk("R2 sweep", longint'(s_res), r);
                        2: chk("R3 sweep", longint'(s_res), r);
                        3: chk("R4 sweep", longint'(s_res), r);
                        4: chk("R5 sweep", longint'(s_res), r);
                        default: chk("R10 sweep", longint'(s_res), r);
                    endcase
                end
            end
        end
        @(negedge clk);
        // R7: the sweep instance saw many events and a clear with valid low.
        chk("R7 valid low ignores events", longint'(s_q), 0);

        // Directed 32-bit scenarios.
        step("R1 wrap sets flag", 1, 0, 0, 32'h7FFF_FFFF, 32'h0000_0001);
        step("R7 hold without event", 1, 0, 3, 32'h0000_0001, 32'h0000_0002);
        step("R7 clear ignored when idle", 0, 1, 1, 32'h0000_0005, 32'h0000_0003);
        step("R8 clear", 1, 1, 1, 32'h0000_0001, 32'h0000_0001);
        step("R2 negative clamp", 1, 0, 1, 32'h8000_0000, 32'hFFFF_FFFF);
        step("R8 set wins over clear", 1, 1, 4, 32'h0000_0000, 32'h0000_0001);
        step("R8 clear again", 1, 1, 0, 32'h0000_0010, 32'h0000_0020);
        step("R3 positive clamp", 1, 0, 2, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        step("R8 clear before R3", 1, 1, 2, 32'h0000_0009, 32'h0000_0004);
        step("R3 negative clamp", 1, 0, 2, 32'h8000_0000, 32'h0000_0001);
        step("R3 zero minus min", 1, 0, 2, 32'h0000_0000, 32'h8000_0000);
        step("R4 carry clamp", 1, 0, 3, 32'hFFFF_FFFF, 32'h0000_0001);
        step("R5 equal operands", 1, 1, 4, 32'h0000_0005, 32'h0000_0005);
        step("R2 no overflow", 1, 0, 1, 32'hFFFF_FFFE, 32'h0000_0001);
        step("R10 code 6 wraps and flags", 1, 0, 6, 32'h7FFF_FFFF, 32'h0000_0001);
        step("R10 code 7 no event", 1, 1, 7, 32'h1234_5678, 32'h1111_1111);

        // R9: reset in the middle of a run clears a set flag.
        step("R6 set before reset", 1, 0, 3, 32'hFFFF_FFF0, 32'h0000_0100);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R9 mid-run reset", longint'(q), 0);
        @(negedge clk);
        rst_n = 1'b1;
        q_exp = 1'b0;
        step("R9 stays clear after reset", 1, 0, 0, 32'h0000_0001, 32'h0000_0001);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule